// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Register Block

This block is the software-facing register file of a DMA dispatcher. A simple word-addressed read/write bus reaches five 32-bit registers: a status word, a control word, two fill-level readbacks and one sequence-number readback. The status word mixes live engine state (busy, descriptor and response buffer empty/full, stopped, resetting) with sticky event bits. The sticky bits stay set until software writes a 1 to them.

The engine reports completion, error and early-termination events as single-cycle pulses. It also supplies a busy level, its buffer fill levels and its sequence counters. In return the block drives a halt request, a descriptor-fetch stop, a flush request for a timed soft reset, and an interrupt line gated by a global enable. When stop-on-error or stop-on-early is armed and the matching event arrives, the engine is held halted until software clears the sticky cause.

Top module: `dma_disp_csr`

## Requirements
- R1: After reset the status word reads 0x00A when busy is low and all fill levels are zero (bit 1 descriptor-empty and bit 3 response-empty set). The control word reads 0, and irq and eng_halt are low.
- R2: Status bit 0 follows eng_busy. Bit 1 is set when both descriptor fills are zero. Bit 2 is set when either descriptor fill is at least DESC_DEPTH. Bit 3 is set when resp_fill is zero. Bit 4 is set when resp_fill is at least RESP_DEPTH. Each bit follows its input in the same cycle.
- R3: Word 2 reads {desc_wr_fill, desc_rd_fill}, word 3 reads resp_fill in bits 15:0 with zeros above, and word 4 reads {wr_seq, rd_seq}. Unmapped words read 0.
- R4: Word 1 (control) stores bit 0 stop, bit 2 stop-on-error, bit 3 stop-on-early, bit 4 interrupt enable and bit 5 fetch stop. Bits 31:6 read 0, and stop_fetch equals bit 5.
- R5: Status bit 9 (interrupt pending) sets one cycle after ev_done pulses with ev_done_ie high. ev_done with ev_done_ie low leaves it clear.
- R6: irq is high exactly when status bit 9 is set and control bit 4 is set.
- R7: Writing word 0 clears each of status bits 7, 8 and 9 whose data bit is 1 and leaves the others. Writing 0x3FF clears all three, and writing 0 changes nothing.
- R8: With control bit 2 set, ev_error sets status bit 7. Without bit 2, ev_error has no effect.
- R9: With control bit 3 set, ev_early sets status bit 8. Without bit 3, ev_early has no effect.
- R10: Writing control bit 1 while no reset is running starts a soft reset. For exactly RST_CYCLES cycles after the write, status bit 6, control bit 1 and flush_req are high. The write also clears status bits 7 to 9.
- R11: When a sticky event and a write-1 clear of the same bit happen in the same cycle, the bit ends up set.
- R12: Status bit 5 and eng_halt are high whenever control bit 0, status bit 7, status bit 8 or a running reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Word address (0 status, 1 control, 2 fills, 3 response fill, 4 sequence) |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the addressed word (combinational) |
| eng_busy | input | 1 | Engine busy level |
| desc_rd_fill | input | 16 | Read-descriptor buffer fill level |
| desc_wr_fill | input | 16 | Write-descriptor buffer fill level |
| resp_fill | input | 16 | Response buffer fill level |
| rd_seq | input | 16 | Read sequence number |
| wr_seq | input | 16 | Write sequence number |
| ev_done | input | 1 | Descriptor completion pulse |
| ev_done_ie | input | 1 | Completed descriptor had its interrupt enabled |
| ev_error | input | 1 | Transfer error pulse |
| ev_early | input | 1 | Early termination pulse |
| eng_halt | output | 1 | Hold the engine stopped |
| stop_fetch | output | 1 | Stop fetching descriptors |
| flush_req | output | 1 | Soft reset in progress, flush buffers |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or lost sticky bit appears on the status readback and on irq or eng_halt in the cycle after the event or clear write. That makes set, clear and collision ordering visible within one clock. A reset counter that is off by one shows as flush_req and the resetting bit dropping one cycle early or late, so its length is counted cycle by cycle. The live status bits are combinational from the inputs, so a wrong threshold shows the moment a fill level reaches the boundary.

// File: rtl/dma_disp_csr_pkg.sv
package dma_disp_csr_pkg;
  localparam int unsigned FILL_W = 16;

  localparam int unsigned ADR_STATUS  = 0;
  localparam int unsigned ADR_CONTROL = 1;
  localparam int unsigned ADR_FILLS   = 2;
  localparam int unsigned ADR_RESP    = 3;
  localparam int unsigned ADR_SEQ     = 4;

  localparam int unsigned ST_BUSY   = 0;
  localparam int unsigned ST_DEMPTY = 1;
  localparam int unsigned ST_DFULL  = 2;
  localparam int unsigned ST_REMPTY = 3;
  localparam int unsigned ST_RFULL  = 4;
  localparam int unsigned ST_HALT   = 5;
  localparam int unsigned ST_RST    = 6;
  localparam int unsigned ST_ERR    = 7;
  localparam int unsigned ST_EARLY  = 8;
  localparam int unsigned ST_IRQ    = 9;
  localparam int unsigned ST_BITS   = 10;

  localparam int unsigned STICKY_N  = 3;

  localparam int unsigned CT_STOP   = 0;
  localparam int unsigned CT_RESET  = 1;
  localparam int unsigned CT_SOE    = 2;
  localparam int unsigned CT_SOEARLY= 3;
  localparam int unsigned CT_GIE    = 4;
  localparam int unsigned CT_FETCH  = 5;
  localparam int unsigned CT_BITS   = 6;
endpackage

// File: rtl/dma_disp_sticky.sv
module dma_disp_sticky #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q;
  logic [N-1:0] q_d;

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_comb begin
      if (flush_i) begin
        q_d[b] = 1'b0;
      end else if (set_i[b]) begin
        q_d[b] = 1'b1;
      end else if (clr_i[b]) begin
        q_d[b] = 1'b0;
      end else begin
        q_d[b] = q_q[b];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_q[b] <= 1'b0;
      end else begin
        q_q[b] <= q_d[b];
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/dma_disp_rst_seq.sv
module dma_disp_rst_seq #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign active_o = (cnt_q != '0);
  assign cnt_en   = active_o | start_i;

  always_comb begin
    if (!active_o) begin
      cnt_d = LOAD;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/dma_disp_csr.sv
module dma_disp_csr
  import dma_disp_csr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DESC_DEPTH = 8,
  parameter int unsigned RESP_DEPTH = 8,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              eng_busy,
  input  logic [15:0]       desc_rd_fill,
  input  logic [15:0]       desc_wr_fill,
  input  logic [15:0]       resp_fill,
  input  logic [15:0]       rd_seq,
  input  logic [15:0]       wr_seq,
  input  logic              ev_done,
  input  logic              ev_done_ie,
  input  logic              ev_error,
  input  logic              ev_early,
  output logic              eng_halt,
  output logic              stop_fetch,
  output logic              flush_req,
  output logic              irq
);
  localparam logic [FILL_W-1:0] DESC_FULL = FILL_W'(DESC_DEPTH);
  localparam logic [FILL_W-1:0] RESP_FULL = FILL_W'(RESP_DEPTH);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  // Write decode.
  logic st_we;
  logic ctl_we;
  assign st_we  = csr_wr && (csr_addr == ADDR_W'(ADR_STATUS));
  assign ctl_we = csr_wr && (csr_addr == ADDR_W'(ADR_CONTROL));

  // Control register (bit 1 is not stored; it reads the reset sequencer).
  logic [CT_BITS-1:0] ctl_q;
  logic [CT_BITS-1:0] ctl_d;

  always_comb begin
    ctl_d           = csr_wdata[CT_BITS-1:0];
    ctl_d[CT_RESET] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  // Soft reset sequencer.
  logic rst_start;
  logic resetting;
  assign rst_start = ctl_we && csr_wdata[CT_RESET] && !resetting;

  dma_disp_rst_seq #(.CYCLES(RST_CYCLES)) u_rst_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (rst_start),
    .active_o (resetting)
  );

  // Sticky status: index 0 error stop, 1 early stop, 2 interrupt pending.
  logic [STICKY_N-1:0] sticky_set;
  logic [STICKY_N-1:0] sticky_clr;
  logic [STICKY_N-1:0] sticky_q;

  assign sticky_set = {ev_done & ev_done_ie,
                       ev_early & ctl_q[CT_SOEARLY],
                       ev_error & ctl_q[CT_SOE]};
  assign sticky_clr = st_we ? csr_wdata[ST_IRQ:ST_ERR] : '0;

  dma_disp_sticky #(.N(STICKY_N)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .set_i   (sticky_set),
    .clr_i   (sticky_clr),
    .flush_i (rst_start),
    .q_o     (sticky_q)
  );

  logic irq_pend;
  logic ctl_gie;
  logic ctl_soe;
  assign irq_pend = sticky_q[2];
  assign ctl_gie  = ctl_q[CT_GIE];
  assign ctl_soe  = ctl_q[CT_SOE];

  // Status composition.
  logic [ST_BITS-1:0] status;
  logic               halt;

  assign halt = ctl_q[CT_STOP] | sticky_q[0] | sticky_q[1] | resetting;

  always_comb begin
    status            = '0;
    status[ST_BUSY]   = eng_busy;
    status[ST_DEMPTY] = (desc_rd_fill == '0) && (desc_wr_fill == '0);
    status[ST_DFULL]  = (desc_rd_fill >= DESC_FULL) || (desc_wr_fill >= DESC_FULL);
    status[ST_REMPTY] = (resp_fill == '0);
    status[ST_RFULL]  = (resp_fill >= RESP_FULL);
    status[ST_HALT]   = halt;
    status[ST_RST]    = resetting;
    status[ST_ERR]    = sticky_q[0];
    status[ST_EARLY]  = sticky_q[1];
    status[ST_IRQ]    = sticky_q[2];
  end

  // Read mux.
  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      ADDR_W'(ADR_STATUS):  csr_rdata[ST_BITS-1:0] = status;
      ADDR_W'(ADR_CONTROL): begin
        csr_rdata[CT_BITS-1:0] = ctl_q;
        csr_rdata[CT_RESET]    = resetting;
      end
      ADDR_W'(ADR_FILLS):   csr_rdata = {desc_wr_fill, desc_rd_fill};
      ADDR_W'(ADR_RESP):    csr_rdata[15:0] = resp_fill;
      ADDR_W'(ADR_SEQ):     csr_rdata = {wr_seq, rd_seq};
      default:              csr_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^csr_wdata[31:ST_BITS];

  assign eng_halt   = halt;
  assign stop_fetch = ctl_q[CT_FETCH];
  assign flush_req  = resetting;
  assign irq        = irq_pend & ctl_gie;
endmodule

// File: rtl/dma_disp_csr_chk.sv
module dma_disp_csr_chk #(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_wr,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [31:0]       csr_wdata,
  input logic              ev_done,
  input logic              ev_done_ie,
  input logic              ev_error,
  input logic              irq,
  input logic              eng_halt,
  input logic              flush_req,
  input logic              irq_pend,
  input logic              ctl_gie,
  input logic              ctl_soe
);
  logic [15:0] flush_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_len <= '0;
    end else if (flush_req) begin
      flush_len <= flush_len + 16'd1;
    end else begin
      flush_len <= '0;
    end
  end

  assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && ev_done_ie) |=> irq_pend);

  assert_irq_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && ev_done_ie && ctl_gie && !(csr_wr && csr_addr == ADDR_W'(1)))
    |=> irq);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_addr == ADDR_W'(0) && csr_wdata[9] && !(ev_done && ev_done_ie))
    |=> !irq_pend);

  assert_err_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_error && ctl_soe) |=> eng_halt);

  assert_reset_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_addr == ADDR_W'(1) && csr_wdata[1] && !flush_req) |=> flush_req);

  assert_reset_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_req) |-> (flush_len == 16'(RST_CYCLES)));
endmodule

bind dma_disp_csr dma_disp_csr_chk #(
  .ADDR_W     (ADDR_W),
  .RST_CYCLES (RST_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .csr_wr     (csr_wr),
  .csr_addr   (csr_addr),
  .csr_wdata  (csr_wdata),
  .ev_done    (ev_done),
  .ev_done_ie (ev_done_ie),
  .ev_error   (ev_error),
  .irq        (irq),
  .eng_halt   (eng_halt),
  .flush_req  (flush_req),
  .irq_pend   (irq_pend),
  .ctl_gie    (ctl_gie),
  .ctl_soe    (ctl_soe)
);

// File: tb/dma_disp_csr_tb.sv
module dma_disp_csr_tb;
  logic        clk;
  logic        rst_n;
  logic        csr_wr;
  logic [2:0]  csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        eng_busy;
  logic [15:0] desc_rd_fill, desc_wr_fill, resp_fill, rd_seq, wr_seq;
  logic        ev_done, ev_done_ie, ev_error, ev_early;
  logic        eng_halt, stop_fetch, flush_req, irq;

  int n_cmp;
  int n_bad;

  dma_disp_csr u_dut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .eng_busy(eng_busy),
    .desc_rd_fill(desc_rd_fill), .desc_wr_fill(desc_wr_fill),
    .resp_fill(resp_fill), .rd_seq(rd_seq), .wr_seq(wr_seq),
    .ev_done(ev_done), .ev_done_ie(ev_done_ie), .ev_error(ev_error),
    .ev_early(ev_early), .eng_halt(eng_halt), .stop_fetch(stop_fetch),
    .flush_req(flush_req), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {busy, rd_fill, wr_fill, resp_fill, expected status}
  localparam logic [79:0] VEC [0:6] = '{
    {16'd0, 16'd0, 16'd0, 16'd0, 16'h000A},
    {16'd1, 16'd0, 16'd0, 16'd0, 16'h000B},
    {16'd0, 16'd3, 16'd0, 16'd2, 16'h0000},
    {16'd0, 16'd8, 16'd0, 16'd0, 16'h000C},
    {16'd1, 16'd0, 16'd5, 16'd8, 16'h0011},
    {16'd0, 16'd0, 16'd9, 16'd8, 16'h0014},
    {16'd0, 16'd0, 16'd0, 16'd9, 16'h0012}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0;
  endtask

  task automatic pulse(input logic done, input logic ie, input logic err, input logic early);
    @(negedge clk);
    ev_done = done; ev_done_ie = ie; ev_error = err; ev_early = early;
    @(negedge clk);
    ev_done = 1'b0; ev_done_ie = 1'b0; ev_error = 1'b0; ev_early = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; csr_wr = 1'b0; csr_addr = '0; csr_wdata = '0;
    eng_busy = 1'b0; desc_rd_fill = '0; desc_wr_fill = '0; resp_fill = '0;
    rd_seq = '0; wr_seq = '0;
    ev_done = 1'b0; ev_done_ie = 1'b0; ev_error = 1'b0; ev_early = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, d); chk("R1 status after reset", d, 32'h00A);
    rd(3'd1, d); chk("R1 control after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 eng_halt after reset", {31'b0, eng_halt}, 32'h0);

    // R2 live status bits from the vector table
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      eng_busy     = VEC[i][64];
      desc_rd_fill = VEC[i][63:48];
      desc_wr_fill = VEC[i][47:32];
      resp_fill    = VEC[i][31:16];
      rd(3'd0, d);
      chk($sformatf("R2 live status vector %0d", i), d, {16'b0, VEC[i][15:0]});
    end
    eng_busy = 1'b0; desc_rd_fill = '0; desc_wr_fill = '0; resp_fill = '0;

    // R3 readback words
    desc_rd_fill = 16'h1234; desc_wr_fill = 16'h0005; resp_fill = 16'h0007;
    rd_seq = 16'hBEEF; wr_seq = 16'h0042;
    rd(3'd2, d); chk("R3 fill word", d, 32'h0005_1234);
    rd(3'd3, d); chk("R3 response fill word", d, 32'h0000_0007);
    rd(3'd4, d); chk("R3 sequence word", d, 32'h0042_BEEF);
    rd(3'd6, d); chk("R3 unmapped word", d, 32'h0);
    desc_rd_fill = '0; desc_wr_fill = '0; resp_fill = '0; rd_seq = '0; wr_seq = '0;

    // R4 / R12 control storage and stop
    wr(3'd1, 32'hFFFF_FFFD);
    rd(3'd1, d); chk("R4 control readback", d, 32'h3D);
    chk("R4 stop_fetch", {31'b0, stop_fetch}, 32'h1);
    chk("R12 halt from stop bit", {31'b0, eng_halt}, 32'h1);
    rd(3'd0, d); chk("R12 status stopped bit", d, 32'h02A);
    wr(3'd1, 32'h0);
    rd(3'd1, d); chk("R4 control cleared", d, 32'h0);
    chk("R12 halt released", {31'b0, eng_halt}, 32'h0);

    // R5 interrupt pending
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    rd(3'd0, d); chk("R5 done without ie", d, 32'h00A);
    pulse(1'b1, 1'b1, 1'b0, 1'b0);
    rd(3'd0, d); chk("R5 done with ie", d, 32'h20A);
    chk("R6 irq masked", {31'b0, irq}, 32'h0);

    // R6 gating
    wr(3'd1, 32'h10);
    chk("R6 irq enabled", {31'b0, irq}, 32'h1);
    wr(3'd1, 32'h0);
    chk("R6 irq disabled again", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h10);

    // R7 write-one-to-clear
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R7 zero write keeps", d, 32'h20A);
    wr(3'd0, 32'h200);
    rd(3'd0, d); chk("R7 irq cleared", d, 32'h00A);
    chk("R7 irq line low", {31'b0, irq}, 32'h0);

    // R8 stop on error
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    rd(3'd0, d); chk("R8 error ignored unarmed", d, 32'h00A);
    chk("R8 halt unarmed", {31'b0, eng_halt}, 32'h0);
    wr(3'd1, 32'h14);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    rd(3'd0, d); chk("R8 error stop", d, 32'h0AA);
    chk("R8 halt held", {31'b0, eng_halt}, 32'h1);
    pulse(1'b1, 1'b1, 1'b0, 1'b0);
    wr(3'd0, 32'h200);
    rd(3'd0, d); chk("R7 selective clear", d, 32'h0AA);
    wr(3'd0, 32'h3FF);
    rd(3'd0, d); chk("R7 clear all", d, 32'h00A);
    chk("R8 halt released", {31'b0, eng_halt}, 32'h0);

    // R9 stop on early termination
    wr(3'd1, 32'h10);
    pulse(1'b0, 1'b0, 1'b0, 1'b1);
    rd(3'd0, d); chk("R9 early ignored unarmed", d, 32'h00A);
    wr(3'd1, 32'h18);
    pulse(1'b0, 1'b0, 1'b0, 1'b1);
    rd(3'd0, d); chk("R9 early stop", d, 32'h12A);
    chk("R9 halt held", {31'b0, eng_halt}, 32'h1);
    wr(3'd0, 32'h100);
    rd(3'd0, d); chk("R9 early cleared", d, 32'h00A);

    // R11 set wins over clear in the same cycle
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = 3'd0; csr_wdata = 32'h200;
    ev_done = 1'b1; ev_done_ie = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0; csr_wdata = '0; ev_done = 1'b0; ev_done_ie = 1'b0;
    rd(3'd0, d); chk("R11 collision keeps set", d, 32'h20A);
    wr(3'd0, 32'h3FF);

    // R10 soft reset
    wr(3'd1, 32'h14);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    wr(3'd1, 32'h16);
    rd(3'd0, d); chk("R10 resetting status", d, 32'h06A);
    rd(3'd1, d); chk("R10 control reset bit", d, 32'h16);
    chk("R10 flush start", {31'b0, flush_req}, 32'h1);
    repeat (15) @(negedge clk);
    chk("R10 flush last cycle", {31'b0, flush_req}, 32'h1);
    @(negedge clk);
    chk("R10 flush ended", {31'b0, flush_req}, 32'h0);
    rd(3'd1, d); chk("R10 control after reset", d, 32'h14);
    rd(3'd0, d); chk("R10 status after reset", d, 32'h00A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule